// File: doc/BRIEF.md
# Receive Loss-of-Signal Detector

This block sits behind the clock and data recovery stage of a line receiver. On every enabled cycle of the recovered clock it looks at the two recovered rails. A cycle in which neither rail carries a pulse counts as a received zero. After a long unbroken run of zeros it raises a loss-of-signal flag. The flag is also raised by reset. The flag drops again as soon as a pulse arrives.

While the flag is high, the block forces its registered data outputs low. It also names, through a two-bit code, the clock that downstream logic should use. When an auxiliary reference clock is present, that clock takes priority. Otherwise the local oscillator is held at its center frequency if the crystal is present. When the flag is low, the recovered clock is used.

The block runs on the system clock `clk`. `rclk_en` is a one-cycle strobe that marks each recovered bit. Cycles without the strobe neither count nor clear anything.

Top module: `rx_los_detector`

## Requirements
- R1: During reset (`rst_n` sampled low) and on the first cycle after it, `los` is 1, and `pos_out`, `neg_out` and `data_out` are 0.
- R2: A received zero is an enabled cycle in which both `rx_pos` and `rx_neg` are 0. `los` becomes 1 at the clock edge that samples the 175th consecutive received zero.
- R3: An enabled cycle with either rail at 1 restarts the zero run. A run of 174 zeros, a pulse, and then another 174 zeros leaves `los` at 0.
- R4: `los` falls to 0 at the edge that samples the first enabled cycle with a pulse on either rail.
- R5: Cycles with `rclk_en` at 0 do not change `los`, the zero run or the data outputs, whatever the rails carry.
- R6: At each enabled edge, `pos_out` and `neg_out` take the rail values and `data_out` takes their OR. While `los` is 1, all three are 0.
- R7: `clk_sel` is 0 (recovered clock) while `los` is 0. It is 1 (auxiliary reference) while `los` is 1 and `aux_ok` is 1.
- R8: While `los` is 1 and `aux_ok` is 0, `clk_sel` is 2 (centered oscillator) if `xtal_ok` is 1, and 3 (no source) otherwise.
- R9: The zero run saturates instead of wrapping. After any number of zeros, one pulse clears `los`, and the declaration again needs exactly 175 new zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rclk_en | input | 1 | Recovered-bit strobe, one cycle per received bit |
| rx_pos | input | 1 | Recovered positive-rail pulse |
| rx_neg | input | 1 | Recovered negative-rail pulse |
| aux_ok | input | 1 | Auxiliary reference clock present |
| xtal_ok | input | 1 | Crystal present |
| los | output | 1 | Loss-of-signal flag |
| pos_out | output | 1 | Gated positive-rail data |
| neg_out | output | 1 | Gated negative-rail data |
| data_out | output | 1 | Gated single-rail data (OR of rails) |
| clk_sel | output | 2 | Clock source code: 0 recovered, 1 auxiliary, 2 centered oscillator, 3 none |

## Verification
Two pairs of functions can coincide in one cycle. A pulse can land exactly where the 175th zero would have been, so the run restart competes with the declaration. The pulse that clears the flag must also appear on the data outputs in that same cycle. The bench provokes the first pair with runs of 174 zeros followed by a pulse on either rail, and with zero runs split by long gaps in the strobe while the rails toggle. It provokes the second pair by sending single pulses into a declared state. A behavioural model predicts the flag, the three data outputs and the source code, and the bench compares them on every clock.

// File: rtl/los_pkg.sv
// Package: shared types for the receive loss-of-signal detector.
// Assumes: the clock source code is decoded by downstream clock muxing.
package los_pkg;
    typedef enum logic [1:0] {
        CLK_RECOVERED = 2'd0,
        CLK_AUX       = 2'd1,
        CLK_CENTERED  = 2'd2,
        CLK_NONE      = 2'd3
    } clk_src_e;
endpackage

// File: rtl/zero_run_counter.sv
// Module: zero_run_counter
// Counts consecutive received zeros on enabled cycles and saturates at LIMIT.
// A pulse restarts the run. limit_hit flags the cycle whose zero completes the run.
// Assumes: en is a one-cycle strobe per received bit; LIMIT >= 2.
module zero_run_counter #(
    parameter int LIMIT = 175,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          pulse,
    output logic [CW-1:0] run_len,
    output logic          limit_hit
);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
    localparam logic [CW-1:0] TOP  = CW'(LIMIT);

    // Purpose: flag that this enabled zero reaches (or stays at) the limit.
    always_comb begin
        limit_hit = en && !pulse && (run_len >= LAST);
    end

    // Purpose: advance, restart or hold the saturating zero run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (en) begin
            if (pulse) begin
                run_len <= '0;
            end else if (run_len < TOP) begin
                run_len <= run_len + 1'b1;
            end
        end
    end
endmodule

// File: rtl/los_state.sv
// Module: los_state
// Holds the loss-of-signal flag. Reset sets it, a completed zero run sets it,
// and the first enabled pulse clears it. los_nxt exposes the value for the next edge.
// Assumes: synchronous active-low reset.
module los_state (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pulse,
    input  logic limit_hit,
    output logic los,
    output logic los_nxt
);
    // Purpose: next-state decision for the flag.
    always_comb begin
        los_nxt = los;
        if (en) begin
            if (pulse) begin
                los_nxt = 1'b0;
            end else if (limit_hit) begin
                los_nxt = 1'b1;
            end
        end
    end

    // Purpose: flag register, set by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            los <= 1'b1;
        end else begin
            los <= los_nxt;
        end
    end
endmodule

// File: rtl/rail_gate.sv
// Module: rail_gate
// Registers the recovered rails on enabled cycles, forcing them low when the
// flag will be set after this edge. Produces the single-rail OR as well.
// Assumes: rail bit 0 is positive, bit 1 is negative.
module rail_gate #(
    parameter int RAILS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [RAILS-1:0] rails_in,
    input  logic             kill,
    output logic [RAILS-1:0] rails_out,
    output logic             merged_out
);
    for (genvar g = 0; g < RAILS; g++) begin : g_rail
        // Purpose: one gated rail register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rails_out[g] <= 1'b0;
            end else if (en) begin
                rails_out[g] <= rails_in[g] & ~kill;
            end
        end
    end

    // Purpose: single-rail register, the OR of all gated rails.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            merged_out <= 1'b0;
        end else if (en) begin
            merged_out <= (|rails_in) & ~kill;
        end
    end
endmodule

// File: rtl/src_select.sv
// Module: src_select
// Picks the downstream clock source code. Outside loss of signal it picks the
// recovered clock. During loss of signal it prefers the auxiliary reference,
// then the centered oscillator, and otherwise reports no source.
// Assumes: presence flags are already synchronous to clk.
module src_select
    import los_pkg::*;
(
    input  logic     los,
    input  logic     aux_ok,
    input  logic     xtal_ok,
    output clk_src_e sel
);
    // Purpose: priority choice of the clock source.
    always_comb begin
        if (!los) begin
            sel = CLK_RECOVERED;
        end else if (aux_ok) begin
            sel = CLK_AUX;
        end else if (xtal_ok) begin
            sel = CLK_CENTERED;
        end else begin
            sel = CLK_NONE;
        end
    end
endmodule

// File: rtl/rx_los_detector.sv
// Module: rx_los_detector (top)
// Declares loss of signal after ZERO_LIMIT consecutive recovered zeros or after
// reset, gates the data outputs low while declared, and selects the clock source.
// Assumes: rclk_en strobes once per recovered bit; synchronous active-low reset.
module rx_los_detector #(
    parameter int ZERO_LIMIT = 175
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rclk_en,
    input  logic       rx_pos,
    input  logic       rx_neg,
    input  logic       aux_ok,
    input  logic       xtal_ok,
    output logic       los,
    output logic       pos_out,
    output logic       neg_out,
    output logic       data_out,
    output logic [1:0] clk_sel
);
    import los_pkg::*;

    localparam int CW = $clog2(ZERO_LIMIT + 1);

    logic          pulse;
    logic [CW-1:0] run_len;
    logic          limit_hit;
    logic          los_nxt;
    logic [1:0]    rails_q;
    clk_src_e      sel_e;

    // Purpose: a mark on either rail counts as a pulse.
    always_comb begin
        pulse = rx_pos | rx_neg;
    end

    zero_run_counter #(.LIMIT(ZERO_LIMIT), .CW(CW)) u_run (
        .clk(clk), .rst_n(rst_n), .en(rclk_en), .pulse(pulse),
        .run_len(run_len), .limit_hit(limit_hit)
    );

    los_state u_state (
        .clk(clk), .rst_n(rst_n), .en(rclk_en), .pulse(pulse),
        .limit_hit(limit_hit), .los(los), .los_nxt(los_nxt)
    );

    rail_gate #(.RAILS(2)) u_gate (
        .clk(clk), .rst_n(rst_n), .en(rclk_en),
        .rails_in({rx_neg, rx_pos}), .kill(los_nxt),
        .rails_out(rails_q), .merged_out(data_out)
    );

    src_select u_sel (
        .los(los), .aux_ok(aux_ok), .xtal_ok(xtal_ok), .sel(sel_e)
    );

    // Purpose: map internal values to the plain output ports.
    always_comb begin
        pos_out = rails_q[0];
        neg_out = rails_q[1];
        clk_sel = sel_e;
    end

    // Run length is only consumed through limit_hit; keep it visible for debug.
    logic run_unused;
    always_comb run_unused = ^run_len;
endmodule

// File: rtl/rx_los_detector_chk.sv
// Module: rx_los_detector_chk
// Assertion checker bound to rx_los_detector. It keeps its own count of
// consecutive zeros to judge the declaration point.
module rx_los_detector_chk #(
    parameter int ZERO_LIMIT = 175
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rclk_en,
    input logic       rx_pos,
    input logic       rx_neg,
    input logic       aux_ok,
    input logic       xtal_ok,
    input logic       los,
    input logic       pos_out,
    input logic       neg_out,
    input logic       data_out,
    input logic [1:0] clk_sel
);
    logic [15:0] zeros_seen;

    // Purpose: independent saturating count of consecutive enabled zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zeros_seen <= '0;
        end else if (rclk_en) begin
            if (rx_pos || rx_neg) begin
                zeros_seen <= '0;
            end else if (zeros_seen < 16'(ZERO_LIMIT)) begin
                zeros_seen <= zeros_seen + 16'd1;
            end
        end
    end

    assert_declare_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rclk_en && !rx_pos && !rx_neg && zeros_seen == 16'(ZERO_LIMIT - 1)) |=> los);

    assert_no_early_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rclk_en && !rx_pos && !rx_neg && zeros_seen < 16'(ZERO_LIMIT - 1) && !los) |=> !los);

    assert_pulse_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rclk_en && (rx_pos || rx_neg)) |=> !los);

    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rclk_en |=> ($stable(los) && $stable(pos_out) && $stable(neg_out) && $stable(data_out)));

    assert_gated_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        los |-> (!pos_out && !neg_out && !data_out));

    assert_sel_recovered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !los |-> (clk_sel == 2'd0));

    assert_sel_aux_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (los && aux_ok) |-> (clk_sel == 2'd1));

    assert_sel_fallback_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (los && !aux_ok) |-> (clk_sel == (xtal_ok ? 2'd2 : 2'd3)));
endmodule

bind rx_los_detector rx_los_detector_chk #(.ZERO_LIMIT(ZERO_LIMIT)) chk_i (
    .clk(clk), .rst_n(rst_n), .rclk_en(rclk_en), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .aux_ok(aux_ok), .xtal_ok(xtal_ok), .los(los), .pos_out(pos_out),
    .neg_out(neg_out), .data_out(data_out), .clk_sel(clk_sel)
);

// File: tb/rx_los_detector_tb_top.sv
`timescale 1ns/1ps
module rx_los_detector_tb_top;
    localparam int LIMIT = 175;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rclk_en = 1'b0;
    logic       rx_pos = 1'b0;
    logic       rx_neg = 1'b0;
    logic       aux_ok = 1'b0;
    logic       xtal_ok = 1'b1;
    logic       los, pos_out, neg_out, data_out;
    logic [1:0] clk_sel;

    int checks = 0;
    int failures = 0;

    // Reference model state
    int   m_zeros = 0;
    logic m_los = 1'b1;
    logic m_pos = 1'b0, m_neg = 1'b0, m_dat = 1'b0;

    always #2.5 clk = ~clk;

    rx_los_detector #(.ZERO_LIMIT(LIMIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .rclk_en(rclk_en), .rx_pos(rx_pos), .rx_neg(rx_neg),
        .aux_ok(aux_ok), .xtal_ok(xtal_ok), .los(los), .pos_out(pos_out),
        .neg_out(neg_out), .data_out(data_out), .clk_sel(clk_sel)
    );

    task automatic check1(input string tag, input string what, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_sel();
        if (!m_los) return 2'd0;
        if (aux_ok) return 2'd1;
        if (xtal_ok) return 2'd2;
        return 2'd3;
    endfunction

    // Compare every output with the model; tag names the requirement under test.
    task automatic compare(input string tag);
        check1(tag, "los", {1'b0, los}, {1'b0, m_los});
        check1(tag, "pos_out", {1'b0, pos_out}, {1'b0, m_pos});
        check1(tag, "neg_out", {1'b0, neg_out}, {1'b0, m_neg});
        check1(tag, "data_out", {1'b0, data_out}, {1'b0, m_dat});
        check1(tag, "clk_sel", clk_sel, exp_sel());
    endtask

    // Drive one cycle, advance the model, sample after the edge.
    task automatic step(input string tag, input logic e, input logic p, input logic n);
        rclk_en = e; rx_pos = p; rx_neg = n;
        if (!rst_n) begin
            m_los = 1'b1; m_zeros = 0; m_pos = 0; m_neg = 0; m_dat = 0;
        end else if (e) begin
            if (p || n) begin
                m_zeros = 0; m_los = 1'b0;
                m_pos = p; m_neg = n; m_dat = p | n;
            end else begin
                if (m_zeros < LIMIT) m_zeros++;
                if (m_zeros == LIMIT) m_los = 1'b1;
                m_pos = 0; m_neg = 0; m_dat = 0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic zeros(input string tag, input int count);
        for (int i = 0; i < count; i++) step(tag, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) step("R1", 1'b1, 1'b1, 1'b0);
        rst_n = 1'b1;
        step("R1", 1'b0, 1'b0, 1'b0);
        check1("R1", "los after reset", {1'b0, los}, 2'd1);
        // R4: first pulse clears, passes through
        step("R4", 1'b1, 1'b1, 1'b0);
        check1("R4", "los cleared", {1'b0, los}, 2'd0);
        check1("R6", "pos passed", {1'b0, pos_out}, 2'd1);
        // R2: exact declaration point
        zeros("R2", LIMIT - 1);
        check1("R2", "no los at 174", {1'b0, los}, 2'd0);
        zeros("R2", 1);
        check1("R2", "los at 175", {1'b0, los}, 2'd1);
        // R7/R8: source selection during LOS
        aux_ok = 1'b1; step("R7", 1'b0, 1'b0, 1'b0);
        check1("R7", "aux chosen", clk_sel, 2'd1);
        aux_ok = 1'b0; xtal_ok = 1'b1; step("R8", 1'b0, 1'b0, 1'b0);
        check1("R8", "centered", clk_sel, 2'd2);
        xtal_ok = 1'b0; step("R8", 1'b0, 1'b0, 1'b0);
        check1("R8", "none", clk_sel, 2'd3);
        // R4/R6: pulse on both rails clears and shows on outputs
        step("R4", 1'b1, 1'b1, 1'b1);
        check1("R6", "data_out OR", {1'b0, data_out}, 2'd1);
        check1("R7", "recovered while clear", clk_sel, 2'd0);
        aux_ok = 1'b1; step("R7", 1'b0, 1'b0, 1'b0);
        check1("R7", "recovered ignores aux", clk_sel, 2'd0);
        // R3: pulse at position 175 restarts the run
        zeros("R3", LIMIT - 1);
        step("R3", 1'b1, 1'b0, 1'b1);
        check1("R3", "neg passed", {1'b0, neg_out}, 2'd1);
        zeros("R3", LIMIT - 1);
        check1("R3", "no los after restart", {1'b0, los}, 2'd0);
        zeros("R3", 1);
        check1("R2", "los after restart run", {1'b0, los}, 2'd1);
        // R5: idle cycles with toggling rails are ignored
        step("R5", 1'b1, 1'b1, 1'b0);
        zeros("R5", 100);
        for (int i = 0; i < 50; i++) step("R5", 1'b0, i[0], ~i[0]);
        check1("R5", "idle pulses ignored", {1'b0, los}, 2'd0);
        zeros("R5", LIMIT - 101);
        check1("R5", "no los at 174 split", {1'b0, los}, 2'd0);
        zeros("R5", 1);
        check1("R5", "los at 175 split", {1'b0, los}, 2'd1);
        for (int i = 0; i < 20; i++) step("R5", 1'b0, 1'b1, 1'b1);
        check1("R5", "idle keeps los", {1'b0, los}, 2'd1);
        check1("R6", "gated during los", {1'b0, data_out}, 2'd0);
        // R9: long run saturates, then one pulse restarts cleanly
        zeros("R9", 600);
        step("R9", 1'b1, 1'b0, 1'b1);
        check1("R9", "clear after long run", {1'b0, los}, 2'd0);
        zeros("R9", LIMIT - 1);
        check1("R9", "no wrap residue", {1'b0, los}, 2'd0);
        zeros("R9", 1);
        check1("R9", "declared again", {1'b0, los}, 2'd1);
        // R1: reset in the middle of normal traffic
        step("R1", 1'b1, 1'b1, 1'b0);
        zeros("R1", 10);
        rst_n = 1'b0;
        step("R1", 1'b1, 1'b1, 1'b0);
        check1("R1", "reset sets los", {1'b0, los}, 2'd1);
        rst_n = 1'b1;
        step("R1", 1'b1, 1'b0, 1'b0);
        step("R4", 1'b1, 1'b1, 1'b0);
        summary();
        $finish;
    end
endmodule